// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a processor's floating-point unit. Software reaches it through a plain read/write port: a write takes effect on the next clock edge, and the read value is always available from the current state. The arithmetic datapaths feed it in three ways. Four sources raise sticky exception flags: the single/double path, the half-precision path, and a standard-mode copy of each. A compare unit sets the condition nibble. A saturating integer unit sets the cumulative saturation bit.

In the other direction, the register drives the live controls the datapaths consume. These are the rounding mode, flush-to-zero for the single/double path, flush-to-zero for the half-precision path, default-NaN mode and the alternative half-precision format select. Exception trapping is not supported, so the trap-enable bits hold nothing. Flags from the four sources are kept in separate banks and merged by OR when the register is read. The half-precision banks never contribute to the input-denormal flag.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0, `rmode_o` reads 0 and every other control output reads 0.
- R2: A write keeps only the bits under mask 0xF7C80000. These are the condition nibble 31:28, format select 26, default-NaN 25, flush 24, rounding 23:22 and half flush 19. Bits 15:8, 6:5 and 26's neighbour 27 come from other storage or read as zero. The outputs `ahp_o`, `dn_o`, `fz_o`, `fz16_o` and `rmode_o` follow bits 26, 25, 24, 19 and 23:22 of the stored word.
- R3: A write stores bits 18:16 (vector length) and 21:20 (vector stride) separately, and they read back in the same positions.
- R4: Each raise input is a 7-bit vector: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 output-denormal, bit6 input-denormal. A set bit from any of the four sources sets the matching read flag on the next edge, and the flag stays set. The read flags are invalid→0, divide-by-zero→1, overflow→2, underflow→3, inexact→4 and input-denormal→7.
- R5: An output-denormal raise (bit5) is reported as underflow, read bit 3.
- R6: Input-denormal raises from the two half-precision sources never set read bit 7. The same raise from either single/double source does set it.
- R7: A write replaces the flags with written bits 4:0 and 7 and clears the flags held for the other three sources. Raises in the same cycle as a write are dropped.
- R8: A compare pulse writes read bits 31:28 on the next edge. The relation code `cmp_rel` maps 0 equal→0110, 1 less→1000, 2 greater→0010 and 3 unordered→0011. A write in the same cycle wins.
- R9: Read bit 27 is set by `sat_pulse` on the next edge and stays set. A write loads it from written bit 27, and that write wins over a same-cycle pulse.
- R10: `rmode_o` carries the written bits 23:22 (0 nearest-even, 1 toward +inf, 2 toward -inf, 3 toward zero). Both the single/double and half datapaths use this one value.
- R11: When parameter `HALF_EN` is 0, bit 19 is forced to 0 on every write, and `fz16_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| raise_main | input | 7 | Exception raises, single/double path |
| raise_main_std | input | 7 | Exception raises, single/double standard-mode path |
| raise_half | input | 7 | Exception raises, half-precision path |
| raise_half_std | input | 7 | Exception raises, half-precision standard-mode path |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_rel | input | 2 | Compare relation code |
| sat_pulse | input | 1 | Saturation event |
| rmode_o | output | 2 | Rounding mode to datapaths |
| fz_o | output | 1 | Flush-to-zero, single/double |
| fz16_o | output | 1 | Flush-to-zero, half precision |
| dn_o | output | 1 | Default-NaN mode |
| ahp_o | output | 1 | Alternative half-precision format |

## Verification
The hardest case to reach is the merge of separate flag banks. When the same flag is set by a source whose bank a write clears, and also by a source whose bank a write loads, the read value alone cannot tell which bank holds it. The stimulus therefore raises a flag on a half-precision source only and then writes zero, which exposes any bank the write fails to clear. It also sends a raise and a write in the same cycle to confirm that the write wins. Input-denormal raises are sent separately on each of the four sources so that the half-precision mask on bit 7 is seen in isolation.

// File: rtl/fp_status_pkg.sv
// Shared constants, types and helpers for the FP status/control register.
// Assumes a 32-bit register layout with fixed field positions.
package fp_status_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned RAISE_W    = 7;
    localparam int unsigned FLAG_W     = 6;
    localparam int unsigned NUM_SRC    = 4;
    localparam logic [31:0] KEEP_MASK  = 32'hF7C8_0000;

    localparam int unsigned POS_HALF_FZ = 19;
    localparam int unsigned POS_QC      = 27;
    localparam int unsigned POS_LEN     = 16;
    localparam int unsigned LEN_W       = 3;
    localparam int unsigned POS_STRIDE  = 20;
    localparam int unsigned STRIDE_W    = 2;
    localparam int unsigned POS_IDC     = 7;

    // Raise vector bit positions
    localparam int unsigned RS_INV  = 0;
    localparam int unsigned RS_DZ   = 1;
    localparam int unsigned RS_OVF  = 2;
    localparam int unsigned RS_UNF  = 3;
    localparam int unsigned RS_INX  = 4;
    localparam int unsigned RS_ODN  = 5;
    localparam int unsigned RS_IDN  = 6;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } cmp_rel_t;

    // Map a compare relation to the condition nibble
    function automatic logic [3:0] nzcv_of(input cmp_rel_t rel);
        case (rel)
            REL_EQ:  nzcv_of = 4'b0110;
            REL_LT:  nzcv_of = 4'b1000;
            REL_GT:  nzcv_of = 4'b0010;
            default: nzcv_of = 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fp_flag_bank.sv
// Sticky exception flag bank for one datapath source.
// Maps a raw raise vector onto the six stored flags {idc,inx,unf,ovf,dz,inv}.
// KEEP_IDC=0 masks input-denormal; LOAD_ON_WR=1 loads written flags, else a
// write clears the bank.
module fp_flag_bank
    import fp_status_pkg::*;
#(
    parameter bit KEEP_IDC   = 1'b1,
    parameter bit LOAD_ON_WR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FLAG_W-1:0]  wr_flags,
    input  logic [RAISE_W-1:0] raise,
    output logic [FLAG_W-1:0]  flags
);

    logic [FLAG_W-1:0] mapped;

    // Translate the raise vector into stored flag order
    always_comb begin
        mapped[0] = raise[RS_INV];
        mapped[1] = raise[RS_DZ];
        mapped[2] = raise[RS_OVF];
        mapped[3] = raise[RS_UNF] | raise[RS_ODN];
        mapped[4] = raise[RS_INX];
        mapped[5] = KEEP_IDC ? raise[RS_IDN] : 1'b0;
    end

    // Hold flags: write replaces or clears, otherwise accumulate raises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wr_en) begin
            flags <= LOAD_ON_WR ? wr_flags : '0;
        end else begin
            flags <= flags | mapped;
        end
    end

endmodule

// File: rtl/fp_ctrl_store.sv
// Control half of the register: kept mask bits, vector length/stride and
// the saturation bit. Writes win over same-cycle compare and saturation.
module fp_ctrl_store
    import fp_status_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                cmp_valid,
    input  logic [1:0]          cmp_rel,
    input  logic                sat_pulse,
    output logic [REG_W-1:0]    kept,
    output logic [LEN_W-1:0]    vec_len,
    output logic [STRIDE_W-1:0] vec_stride,
    output logic                qc
);

    localparam logic [REG_W-1:0] HALF_CLR =
        HALF_EN ? '1 : ~(REG_W'(1) << POS_HALF_FZ);
    localparam logic [REG_W-1:0] EFF_MASK = KEEP_MASK & HALF_CLR;

    // Update stored control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept       <= '0;
            vec_len    <= '0;
            vec_stride <= '0;
            qc         <= 1'b0;
        end else if (wr_en) begin
            kept       <= wr_data & EFF_MASK;
            vec_len    <= wr_data[POS_LEN +: LEN_W];
            vec_stride <= wr_data[POS_STRIDE +: STRIDE_W];
            qc         <= wr_data[POS_QC];
        end else begin
            if (cmp_valid) begin
                kept[31:28] <= nzcv_of(cmp_rel_t'(cmp_rel));
            end
            if (sat_pulse) begin
                qc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fp_status_ctrl.sv
// FP status/control register top. Four sticky flag banks (main, main
// standard, half, half standard) are OR-merged on read together with the
// control store. Assumes single-cycle raise/compare/saturation pulses.
module fp_status_ctrl
    import fp_status_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic [6:0]         raise_main,
    input  logic [6:0]         raise_main_std,
    input  logic [6:0]         raise_half,
    input  logic [6:0]         raise_half_std,
    input  logic               cmp_valid,
    input  logic [1:0]         cmp_rel,
    input  logic               sat_pulse,
    output logic [1:0]         rmode_o,
    output logic               fz_o,
    output logic               fz16_o,
    output logic               dn_o,
    output logic               ahp_o
);

    logic [RAISE_W-1:0]  raise_arr [NUM_SRC];
    logic [FLAG_W-1:0]   flag_arr  [NUM_SRC];
    logic [FLAG_W-1:0]   wr_flags;
    logic [FLAG_W-1:0]   flag_or;
    logic [REG_W-1:0]    kept;
    logic [LEN_W-1:0]    vec_len;
    logic [STRIDE_W-1:0] vec_stride;
    logic                qc;

    // Gather source raise vectors; index 0/1 single/double, 2/3 half
    always_comb begin
        raise_arr[0] = raise_main;
        raise_arr[1] = raise_main_std;
        raise_arr[2] = raise_half;
        raise_arr[3] = raise_half_std;
    end

    // Written flag bits in stored order
    assign wr_flags = {wr_data[POS_IDC], wr_data[4:0]};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bank
        fp_flag_bank #(
            .KEEP_IDC   (g < 2),
            .LOAD_ON_WR (g == 0)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_flags (wr_flags),
            .raise    (raise_arr[g]),
            .flags    (flag_arr[g])
        );
    end

    // Merge the banks by OR
    always_comb begin
        flag_or = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            flag_or = flag_or | flag_arr[i];
        end
    end

    fp_ctrl_store #(.HALF_EN(HALF_EN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmp_valid  (cmp_valid),
        .cmp_rel    (cmp_rel),
        .sat_pulse  (sat_pulse),
        .kept       (kept),
        .vec_len    (vec_len),
        .vec_stride (vec_stride),
        .qc         (qc)
    );

    // Assemble the read value
    always_comb begin
        rd_data                           = kept;
        rd_data[POS_LEN +: LEN_W]         = vec_len;
        rd_data[POS_STRIDE +: STRIDE_W]   = vec_stride;
        rd_data[POS_QC]                   = qc;
        rd_data[4:0]                      = flag_or[4:0];
        rd_data[POS_IDC]                  = flag_or[5];
    end

    // Export live controls to the datapaths
    assign rmode_o = kept[23:22];
    assign fz_o    = kept[24];
    assign dn_o    = kept[25];
    assign ahp_o   = kept[26];
    assign fz16_o  = kept[POS_HALF_FZ];

endmodule

// File: rtl/fp_status_ctrl_chk.sv
// Property checker for fp_status_ctrl, attached by bind.
module fp_status_ctrl_chk #(
    parameter bit HALF_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [6:0]  raise_main,
    input logic [6:0]  raise_main_std,
    input logic        cmp_valid,
    input logic [1:0]  cmp_rel,
    input logic        sat_pulse,
    input logic [1:0]  rmode_o,
    input logic        fz16_o
);

    AST_TRAP_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:8] == 8'h00 && rd_data[6:5] == 2'b00);  // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[4:0] & $past(rd_data[4:0])) == $past(rd_data[4:0])));  // R4

    AST_HALF_IDC: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !raise_main[6] && !raise_main_std[6] && !rd_data[7]) |=> !rd_data[7]);  // R6

    AST_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[4:0] == $past(wr_data[4:0]) && rd_data[7] == $past(wr_data[7])));  // R7

    AST_CMP_NZCV: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !wr_en) |=> rd_data[31:28] ==
            (($past(cmp_rel) == 2'd0) ? 4'h6 :
             ($past(cmp_rel) == 2'd1) ? 4'h8 :
             ($past(cmp_rel) == 2'd2) ? 4'h2 : 4'h3));  // R8

    AST_QC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_pulse && !wr_en) |=> rd_data[27]);  // R9

    AST_RMODE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rmode_o == $past(wr_data[23:22]));  // R10

    AST_FZ16_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !HALF_EN |-> !fz16_o);  // R11

endmodule

bind fp_status_ctrl fp_status_ctrl_chk #(.HALF_EN(HALF_EN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .raise_main     (raise_main),
    .raise_main_std (raise_main_std),
    .cmp_valid      (cmp_valid),
    .cmp_rel        (cmp_rel),
    .sat_pulse      (sat_pulse),
    .rmode_o        (rmode_o),
    .fz16_o         (fz16_o)
);

// File: tb/test_fp_status_ctrl.sv
// Scoreboard bench: the driver applies one operation per cycle and queues the
// expected register image; the monitor pops and compares at the next falling
// edge. A second instance with half-precision disabled shares the stimulus.
module test_fp_status_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [6:0]  r_main, r_main_std, r_half, r_half_std;
    logic        cmp_valid;
    logic [1:0]  cmp_rel;
    logic        sat_pulse;

    logic [31:0] rd_a, rd_b;
    logic [1:0]  rm_a, rm_b;
    logic        fz_a, fz16_a, dn_a, ahp_a;
    logic        fz_b, fz16_b, dn_b, ahp_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       q[$];
    logic [31:0] model;

    always #5 clk = ~clk;

    fp_status_ctrl #(.HALF_EN(1'b1)) i_fp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_a), .raise_main(r_main), .raise_main_std(r_main_std),
        .raise_half(r_half), .raise_half_std(r_half_std),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel), .sat_pulse(sat_pulse),
        .rmode_o(rm_a), .fz_o(fz_a), .fz16_o(fz16_a), .dn_o(dn_a), .ahp_o(ahp_a)
    );

    fp_status_ctrl #(.HALF_EN(1'b0)) i_fp_status_ctrl_nohalf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_b), .raise_main(r_main), .raise_main_std(r_main_std),
        .raise_half(r_half), .raise_half_std(r_half_std),
        .cmp_valid(cmp_valid), .cmp_rel(cmp_rel), .sat_pulse(sat_pulse),
        .rmode_o(rm_b), .fz_o(fz_b), .fz16_o(fz16_b), .dn_o(dn_b), .ahp_o(ahp_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Requirement-level model of one raise vector into read flag bits
    function automatic logic [31:0] flag_bits(input logic [6:0] r, input bit half);
        logic [31:0] f = '0;
        f[0] = r[0];
        f[1] = r[1];
        f[2] = r[2];
        f[3] = r[3] | r[5];
        f[4] = r[4];
        f[7] = half ? 1'b0 : r[6];
        return f;
    endfunction

    // Driver: one operation, update model, queue expected image
    task automatic step(input logic we, input logic [31:0] wd,
                        input logic [6:0] a, input logic [6:0] b,
                        input logic [6:0] c, input logic [6:0] d,
                        input logic cv, input logic [1:0] cr,
                        input logic sat, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_data = wd;
        r_main = a; r_main_std = b; r_half = c; r_half_std = d;
        cmp_valid = cv; cmp_rel = cr; sat_pulse = sat;
        if (we) begin
            model = (wd & 32'hF7C8_0000) | (wd & 32'h0037_0000) |
                    (wd & 32'h0800_0000) | (wd & 32'h0000_009F);
        end else begin
            model = model | flag_bits(a, 0) | flag_bits(b, 0) |
                    flag_bits(c, 1) | flag_bits(d, 1);
            if (cv) begin
                case (cr)
                    2'd0: model[31:28] = 4'b0110;
                    2'd1: model[31:28] = 4'b1000;
                    2'd2: model[31:28] = 4'b0010;
                    default: model[31:28] = 4'b0011;
                endcase
            end
            if (sat) model[27] = 1'b1;
        end
        @(posedge clk);
        #1;
        it.exp = model;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; wr_data = '0; r_main = '0; r_main_std = '0;
        r_half = '0; r_half_std = '0; cmp_valid = 0; cmp_rel = '0; sat_pulse = 0;
    endtask

    // Monitor: compare both instances against the popped expectation
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] eb;
                it = q.pop_front();
                eb = it.exp & ~32'h0008_0000;
                check({it.tag, " rd"}, rd_a, it.exp);
                check({it.tag, " ctrl_out"}, {26'b0, rm_a, fz_a, fz16_a, dn_a, ahp_a},
                      {26'b0, it.exp[23:22], it.exp[24], it.exp[19], it.exp[25], it.exp[26]});
                check({it.tag, " R11 nohalf rd"}, rd_b, eb);
                check({it.tag, " R11 nohalf fz16"}, {31'b0, fz16_b}, 32'b0);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        item_t it;
        rst_n = 0;
        wr_en = 0; wr_data = '0; r_main = '0; r_main_std = '0;
        r_half = '0; r_half_std = '0; cmp_valid = 0; cmp_rel = '0; sat_pulse = 0;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        it.exp = '0; it.tag = "R1 reset";
        q.push_back(it);

        // R2 R3 R7 R9: write all ones, only kept bits survive
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R2 R3 R9 write ones");
        step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, "R2 write zero");
        step(1, 32'h0025_0000, 0, 0, 0, 0, 0, 0, 0, "R3 len5 stride2");
        // R4: raises from several sources accumulate
        step(0, 0, 7'h01, 0, 0, 0, 0, 0, 0, "R4 main invalid");
        step(0, 0, 0, 0, 0, 7'h04, 0, 0, 0, "R4 half_std overflow");
        step(0, 0, 0, 0, 7'h12, 0, 0, 0, 0, "R4 half dz+inexact");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 sticky hold");
        step(1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R7 clear");
        // R5: output-denormal reported as underflow
        step(0, 0, 0, 7'h20, 0, 0, 0, 0, 0, "R5 odn to unf");
        step(1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R7 clear");
        // R6: input-denormal masking
        step(0, 0, 0, 0, 7'h40, 0, 0, 0, 0, "R6 half idn ignored");
        step(0, 0, 0, 0, 0, 7'h40, 0, 0, 0, "R6 half_std idn ignored");
        step(0, 0, 0, 7'h40, 0, 0, 0, 0, 0, "R6 main_std idn sets");
        step(1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R7 clear");
        step(0, 0, 7'h40, 0, 0, 0, 0, 0, 0, "R6 main idn sets");
        // R7: half bank cleared by write, write beats raise
        step(0, 0, 0, 0, 7'h02, 0, 0, 0, 0, "R7 half dz");
        step(1, 32'h0000_0010, 7'h01, 7'h04, 7'h08, 7'h02, 0, 0, 0, "R7 write wins");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 others cleared");
        step(1, 32'h0000_0089, 0, 0, 0, 0, 0, 0, 0, "R7 load idc");
        // R8: compare encodings
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0, 0, 0, 0, 1, 2'(k), 0, "R8 compare");
        end
        step(1, 32'h5000_0000, 0, 0, 0, 0, 1, 2'd1, 0, "R8 write beats compare");
        // R9: saturation bit
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 sat sets");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 sat sticky");
        step(1, 32'h0, 0, 0, 0, 0, 0, 0, 1, "R9 write clears");
        step(1, 32'h0800_0000, 0, 0, 0, 0, 0, 0, 0, "R9 write loads");
        // R10: rounding modes
        for (int m = 0; m < 4; m++) begin
            step(1, 32'(m) << 22, 0, 0, 0, 0, 0, 0, 0, "R10 rmode");
        end
        // R2 R11: individual control exports
        step(1, 32'h0108_0000, 0, 0, 0, 0, 0, 0, 0, "R2 R11 fz fz16");
        step(1, 32'h0600_0000, 0, 0, 0, 0, 0, 0, 0, "R2 dn ahp");
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule